// File: doc/BRIEF.md
# Twelve-Hour Seconds Clock with Seven-Segment Digit Ports

This block keeps time of day over a twelve-hour span and drives six seven-segment digits. A fixed chain of three down-counters runs from the system clock. The first counter divides the clock down to a 25 ms tick. The second counter divides that tick to one pulse per second. The third counter counts those pulses modulo the number of seconds in twelve hours. Each counter reloads its start value by itself when it reaches its terminal count. With the default 2 MHz clock, the divide ratios are 50000, 40 and 43200.

After each one-second pulse, a short sequential converter turns the elapsed-second count into hours, minutes and seconds by restoring division. Hours take 4 steps and minutes take 6. It then latches three 8-bit BCD digit-pair ports in the same clock edge and raises a one-cycle update strobe. The segment patterns for all six digits are decoded from those ports. The reload values are parameters, so a test build can run the chain at a much higher tick rate.

Top module: `hms_tick_clock`

## Requirements
- R1: A synchronous reset reloads all three counters, clears the seconds, minutes and hours ports to 8'h00 and holds the update strobe low.
- R2: The update strobe is high for exactly one cycle. Outside reset it recurs every DIV_FAST*DIV_SLOW clock cycles, and that product must be at least 14.
- R3: On the k-th strobe after reset, the ports show k elapsed seconds modulo SPAN.
- R4: The seconds port holds the tens digit in bits [7:4] and the units digit in bits [3:0], and its value is always in the range 00 to 59.
- R5: The minutes port uses the same tens/units layout and its value is always in the range 00 to 59.
- R6: The hours port uses the same tens/units layout and its value is in the range 00 to 11 when SPAN is 43200 or less.
- R7: After SPAN-1 seconds, the next strobe shows 00:00:00, and the count then continues upward.
- R8: The bus `seg` carries six 7-bit active-high patterns in gfedcba order. Digit i uses bits [7i+6:7i], and the digits run from seconds units (i=0) to hours tens (i=5). The patterns for 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).
- R9: The three ports change only at the edge that raises the strobe, and all three change together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock (2 MHz by default) |
| rst | input | 1 | Synchronous active-high reset |
| sec_bcd | output | 8 | Seconds as two BCD digits |
| min_bcd | output | 8 | Minutes as two BCD digits |
| hr_bcd | output | 8 | Hours as two BCD digits |
| seg | output | 42 | Six seven-segment patterns, seconds units in the low bits |
| upd | output | 1 | One-cycle strobe marking a fresh time value |

## Verification
A divider counter with a wrong value shows up at the ports within two strobes, because the spacing between strobes is wrong. A third-stage counter with a wrong value shows up on the very next strobe as a wrong elapsed count. A converter that keeps a stale remainder or quotient bit shows up as a wrong or non-BCD digit pair on the strobe where it happens. Wrap errors appear only near the SPAN boundary, so the bench runs a shortened span through its wrap.

// File: rtl/hms_tick_clock.sv
module hms_tick_clock #(
  parameter int DIV_FAST = 50000,
  parameter int DIV_SLOW = 40,
  parameter int SPAN     = 43200
) (
  input  logic        clk,
  input  logic        rst,
  output logic [7:0]  sec_bcd,
  output logic [7:0]  min_bcd,
  output logic [7:0]  hr_bcd,
  output logic [41:0] seg,
  output logic        upd
);
  localparam int W1 = $clog2(DIV_FAST + 1);
  localparam int W2 = $clog2(DIV_SLOW + 1);
  localparam int W3 = $clog2(SPAN + 1);

  logic [W1-1:0] c1;
  logic [W2-1:0] c2;
  logic [W3-1:0] c3;

  wire t25 = (c1 == W1'(1));
  wire t1s = t25 && (c2 == W2'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      c1 <= W1'(DIV_FAST);
      c2 <= W2'(DIV_SLOW);
      c3 <= W3'(SPAN);
    end else begin
      c1 <= t25 ? W1'(DIV_FAST) : c1 - W1'(1);
      if (t25) c2 <= (c2 == W2'(1)) ? W2'(DIV_SLOW) : c2 - W2'(1);
      if (t1s) c3 <= (c3 == W3'(1)) ? W3'(SPAN) : c3 - W3'(1);
    end
  end

  wire [W3-1:0] elapsed = (c3 == W3'(SPAN)) ? '0 : W3'(SPAN) - c3;

  logic        start, busy, done;
  logic [3:0]  ph;
  logic [16:0] rem;
  logic [9:0]  q;

  wire [16:0] dv = (ph < 4'd4) ? (17'd3600 << (4'd3 - ph)) : (17'd60 << (4'd9 - ph));
  wire        ge = (rem >= dv);

  always_ff @(posedge clk) begin
    if (rst) begin
      start <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
      ph    <= '0;
      rem   <= '0;
      q     <= '0;
    end else begin
      start <= t1s;
      done  <= 1'b0;
      if (start) begin
        rem  <= 17'(elapsed);
        q    <= '0;
        ph   <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        q  <= {q[8:0], ge};
        if (ge) rem <= rem - dv;
        ph <= ph + 4'd1;
        if (ph == 4'd9) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  function automatic logic [7:0] to_bcd(input logic [5:0] v);
    return {4'(v / 6'd10), 4'(v % 6'd10)};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_bcd <= 8'h00;
      min_bcd <= 8'h00;
      hr_bcd  <= 8'h00;
      upd     <= 1'b0;
    end else begin
      upd <= done;
      if (done) begin
        sec_bcd <= to_bcd(rem[5:0]);
        min_bcd <= to_bcd(q[5:0]);
        hr_bcd  <= to_bcd({2'b00, q[9:6]});
      end
    end
  end

  function automatic logic [6:0] enc(input logic [3:0] d);
    case (d)
      4'd0: enc = 7'h3F;
      4'd1: enc = 7'h06;
      4'd2: enc = 7'h5B;
      4'd3: enc = 7'h4F;
      4'd4: enc = 7'h66;
      4'd5: enc = 7'h6D;
      4'd6: enc = 7'h7D;
      4'd7: enc = 7'h07;
      4'd8: enc = 7'h7F;
      4'd9: enc = 7'h6F;
      default: enc = 7'h00;
    endcase
  endfunction

  wire [23:0] digs = {hr_bcd, min_bcd, sec_bcd};

  for (genvar i = 0; i < 6; i++) begin : g_seg
    assign seg[7*i +: 7] = enc(digs[4*i +: 4]);
  end
endmodule

// File: rtl/hms_tick_clock_chk.sv
module hms_tick_clock_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] sec_bcd,
  input logic [7:0] min_bcd,
  input logic [7:0] hr_bcd,
  input logic       upd
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (sec_bcd == 8'h00 && min_bcd == 8'h00 && hr_bcd == 8'h00 && !upd));

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
    upd |=> !upd);

  p_sec_digits_r4: assert property (@(posedge clk) disable iff (rst)
    sec_bcd[3:0] <= 4'd9 && sec_bcd[7:4] <= 4'd5);

  p_min_digits_r5: assert property (@(posedge clk) disable iff (rst)
    min_bcd[3:0] <= 4'd9 && min_bcd[7:4] <= 4'd5);

  p_hr_digits_r6: assert property (@(posedge clk) disable iff (rst)
    hr_bcd[3:0] <= 4'd9 && hr_bcd <= 8'h11);

  p_ports_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !upd |-> $stable({hr_bcd, min_bcd, sec_bcd}));
endmodule

bind hms_tick_clock hms_tick_clock_chk u_chk (
  .clk(clk), .rst(rst), .sec_bcd(sec_bcd), .min_bcd(min_bcd),
  .hr_bcd(hr_bcd), .upd(upd)
);

// File: tb/sim_hms_tick_clock.sv
module sim_hms_tick_clock;
  localparam int DF = 3;
  localparam int DS = 5;
  localparam int SP = 7400;
  localparam int PER = DF * DS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] sec_bcd, min_bcd, hr_bcd;
  logic [41:0] seg;
  logic upd;

  int vectors = 0;
  int errs = 0;
  int cyc = 0;
  int tick = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hms_tick_clock #(.DIV_FAST(DF), .DIV_SLOW(DS), .SPAN(SP)) u0 (
    .clk(clk), .rst(rst), .sec_bcd(sec_bcd), .min_bcd(min_bcd),
    .hr_bcd(hr_bcd), .seg(seg), .upd(upd)
  );

  function automatic logic [7:0] pair(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [23:0] exp_ports(input int k);
    int e = k % SP;
    return {pair(e / 3600), pair((e / 60) % 60), pair(e % 60)};
  endfunction

  function automatic logic [6:0] pat(input logic [3:0] d);
    case (d)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
      4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
      4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
      4'd9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  function automatic logic [41:0] exp_seg(input logic [23:0] p);
    logic [41:0] s;
    for (int i = 0; i < 6; i++) s[7*i +: 7] = pat(p[4*i +: 4]);
    return s;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_reset();
    chk("R1 ports", 64'({hr_bcd, min_bcd, sec_bcd}), 64'h0);
    chk("R1 strobe", 64'(upd), 64'h0);
    chk("R8 reset segments", 64'(seg), 64'(exp_seg(24'h0)));
  endtask

  task automatic run(input int n);
    int last = -1;
    logic [23:0] held = {hr_bcd, min_bcd, sec_bcd};
    for (int i = 0; i < n; i++) begin
      int guard = 0;
      bit moved = 0;
      @(negedge clk);
      while (!upd && guard < 4 * PER) begin
        if ({hr_bcd, min_bcd, sec_bcd} !== held) moved = 1;
        @(negedge clk);
        guard++;
      end
      if (!upd) begin
        chk("R2 strobe missing", 64'(upd), 64'h1);
        return;
      end
      chk("R9 ports held between strobes", 64'(moved), 64'h0);
      tick++;
      chk("R3 R4 R5 R6 R7 ports", 64'({hr_bcd, min_bcd, sec_bcd}), 64'(exp_ports(tick)));
      chk("R8 segments", 64'(seg), 64'(exp_seg(exp_ports(tick))));
      if (last >= 0) chk("R2 spacing", 64'(cyc - last), 64'(PER));
      last = cyc;
      held = {hr_bcd, min_bcd, sec_bcd};
      @(negedge clk);
      chk("R2 width", 64'(upd), 64'h0);
      if ({hr_bcd, min_bcd, sec_bcd} !== held) chk("R9 ports after strobe", 64'({hr_bcd, min_bcd, sec_bcd}), 64'(held));
    end
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd1729));
    repeat (3) @(negedge clk);
    chk_reset();
    rst = 1'b0;
    tick = 0;
    run(20);
    repeat (1 + ($urandom % 14)) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk_reset();
    rst = 1'b0;
    tick = 0;
    run(SP + 5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule